// File: doc/BRIEF.md
# Flash Identification and Sector Protection Responder

This block sits beside the array read path of a small parallel NOR flash model. It answers the identification reads that a programmer or host issues while a high-voltage level is held on address bit 9. For each such read it returns one 8-bit code. Which code it returns depends on three low-order address bits (A6, A1, A0). The three codes are the maker code, the part code, and the protection status of the sector that the top three address bits name. When any identification condition is missing, the block drops its data-valid output and the array read path owns the data bus.

The block also holds one protect bit for each of eight sectors. A fixture port sets or clears these bits, and it acts only while the high-voltage flag is present. The bits leave the block in two forms: as a vector of per-sector program/erase block signals, and as a single block signal for the sector under the current address. The program and erase engines use these to refuse work on a locked sector.

Top module: `flash_id_responder`

## Requirements
- R1: `id_valid` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1 and `a9_hv`=1; at all other times `id_valid`=0 and `id_data`=00h.
- R2: During an identification read with A6=0, A1=0, A0=0, `id_data` is the maker code 01h.
- R3: During an identification read with A6=0, A1=0, A0=1, `id_data` is the part code 20h.
- R4: During an identification read with A6=0, A1=1, A0=0, `id_data` is 01h when the sector named by A16..A14 is protected and 00h when it is not.
- R5: During an identification read with A6=0 and A1=1, A0=1, or with A6=1, `id_data` is 00h.
- R6: Address bits A13..A10, A8..A7 and A5..A2 do not change the identification result.
- R7: Synchronous active-high `rst` clears every protect bit, so all eight sectors read back unprotected.
- R8: When `upd_en`=1 and `a9_hv`=1 on a clock edge, the protect bit of sector `upd_sector` becomes `upd_set` (1 = protect, 0 = unprotect) from that edge on. No other bit changes.
- R9: When `a9_hv`=0, an update request on `upd_en` has no effect on any protect bit.
- R10: `sector_block[i]` equals the protect bit of sector i, and `addr_blocked` equals the protect bit of the sector named by A16..A14. A set bit blocks both program and erase, and a cleared bit allows both again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the protect register |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Address, A16..A0 |
| a9_hv | input | 1 | High-voltage level present on address bit 9 |
| upd_en | input | 1 | Fixture request to change a protect bit |
| upd_set | input | 1 | New value for the bit: 1 protects, 0 unprotects |
| upd_sector | input | 3 | Sector whose protect bit is changed |
| id_data | output | 8 | Identification code |
| id_valid | output | 1 | Identification code owns the data bus |
| sector_block | output | 8 | Program/erase block, one bit per sector |
| addr_blocked | output | 1 | Program/erase block for the sector under `addr` |

## Verification
The checker tests on every cycle the properties that follow directly from the port values of that cycle or the one before. These are the strobe gating, the fixed codes for each A6/A1/A0 pattern, the fact that an update sets or clears its bit and leaves the rest alone, the freezing of the protect bits without high voltage, the cleared state after reset, and the agreement between the two block outputs. Only the bench scenarios can show that the protection code read back follows a history of updates across different sectors. The same holds for the don't-care address bits: changing them leaves results unchanged, and the bench shows this by varying them on a fixed read.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

    localparam int ADDR_W   = 17;
    localparam int DATA_W   = 8;
    localparam int SECT_W   = 3;
    localparam int NUM_SECT = 1 << SECT_W;

    localparam logic [DATA_W-1:0] MAKER_CODE = 8'h01;
    localparam logic [DATA_W-1:0] PART_CODE  = 8'h20;
    localparam logic [DATA_W-1:0] LOCK_CODE  = 8'h01;
    localparam logic [DATA_W-1:0] OPEN_CODE  = 8'h00;
    localparam logic [DATA_W-1:0] NULL_CODE  = 8'h00;

    typedef enum logic [1:0] {
        SEL_MAKER = 2'd0,
        SEL_PART  = 2'd1,
        SEL_LOCK  = 2'd2,
        SEL_NULL  = 2'd3
    } id_sel_e;

    typedef struct packed {
        logic              active;
        id_sel_e           sel;
        logic [SECT_W-1:0] sector;
    } id_req_t;

    typedef struct packed {
        logic              en;
        logic              value;
        logic [SECT_W-1:0] sector;
    } prot_upd_t;

    // Picks the code for one selector, given the protect bit of the named sector.
    function automatic logic [DATA_W-1:0] code_for(input id_sel_e sel, input logic locked);
        logic [DATA_W-1:0] c;
        case (sel)
            SEL_MAKER: c = MAKER_CODE;
            SEL_PART:  c = PART_CODE;
            SEL_LOCK:  c = locked ? LOCK_CODE : OPEN_CODE;
            default:   c = NULL_CODE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fid_decode.sv
module fid_decode
    import flash_id_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SECT_W
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          a9_hv,
    input  logic [SW-1:0] sect_bits,
    input  logic          a6,
    input  logic          a1,
    input  logic          a0,
    output id_req_t       req
);
    logic strobes_ok;

    // A read cycle with writes held off, and the high voltage on A9.
    assign strobes_ok = !ce_n && !oe_n && we_n && a9_hv;

    always_comb begin
        req.active = strobes_ok;
        req.sector = sect_bits;
        if (a6) begin
            req.sel = SEL_NULL;
        end else begin
            case ({a1, a0})
                2'b00:   req.sel = SEL_MAKER;
                2'b01:   req.sel = SEL_PART;
                2'b10:   req.sel = SEL_LOCK;
                default: req.sel = SEL_NULL;
            endcase
        end
    end
endmodule

// File: rtl/fid_protect_reg.sv
module fid_protect_reg
    import flash_id_pkg::*;
#(
    parameter int NS = NUM_SECT,
    parameter int SW = SECT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  prot_upd_t     upd,
    output logic [NS-1:0] lock_q
);
    for (genvar g = 0; g < NS; g++) begin : g_sect
        logic hit;
        assign hit = upd.en && (upd.sector == SW'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (hit) begin
                lock_q[g] <= upd.value;
            end
        end
    end
endmodule

// File: rtl/fid_out_mux.sv
module fid_out_mux
    import flash_id_pkg::*;
#(
    parameter int NS = NUM_SECT,
    parameter int DW = DATA_W
) (
    input  id_req_t       req,
    input  logic [NS-1:0] lock_q,
    output logic [DW-1:0] data,
    output logic          valid
);
    logic named_locked;

    assign named_locked = lock_q[req.sector];

    always_comb begin
        valid = req.active;
        data  = req.active ? code_for(req.sel, named_locked) : NULL_CODE;
    end
endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
    import flash_id_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                a9_hv,
    input  logic                upd_en,
    input  logic                upd_set,
    input  logic [SECT_W-1:0]   upd_sector,
    output logic [DATA_W-1:0]   id_data,
    output logic                id_valid,
    output logic [NUM_SECT-1:0] sector_block,
    output logic                addr_blocked
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    id_req_t             req;
    prot_upd_t           upd;
    logic [NUM_SECT-1:0] lock_q;
    logic [SECT_W-1:0]   addr_sect;

    assign addr_sect  = addr[ADDR_W-1:SECT_LSB];

    // Fixture writes only count while the high voltage is present.
    assign upd.en     = upd_en && a9_hv;
    assign upd.value  = upd_set;
    assign upd.sector = upd_sector;

    fid_decode #(.AW(ADDR_W), .SW(SECT_W)) u_decode (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .a9_hv     (a9_hv),
        .sect_bits (addr_sect),
        .a6        (addr[6]),
        .a1        (addr[1]),
        .a0        (addr[0]),
        .req       (req)
    );

    fid_protect_reg #(.NS(NUM_SECT), .SW(SECT_W)) u_prot (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .lock_q (lock_q)
    );

    fid_out_mux #(.NS(NUM_SECT), .DW(DATA_W)) u_mux (
        .req    (req),
        .lock_q (lock_q),
        .data   (id_data),
        .valid  (id_valid)
    );

    assign sector_block = lock_q;
    assign addr_blocked = lock_q[addr_sect];
endmodule

// File: rtl/flash_id_responder_chk.sv
module flash_id_responder_chk
    import flash_id_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ce_n,
    input logic                oe_n,
    input logic                we_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                a9_hv,
    input logic                upd_en,
    input logic                upd_set,
    input logic [SECT_W-1:0]   upd_sector,
    input logic [DATA_W-1:0]   id_data,
    input logic                id_valid,
    input logic [NUM_SECT-1:0] sector_block,
    input logic                addr_blocked
);
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n || !we_n || !a9_hv) |-> (!id_valid && id_data == 8'h00)); // R1
    AST_GATE_ON: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n && a9_hv) |-> id_valid); // R1
    AST_MAKER: assert property (@(posedge clk) disable iff (rst)
        (id_valid && addr[6] == 1'b0 && addr[1:0] == 2'b00) |-> id_data == 8'h01); // R2
    AST_PART: assert property (@(posedge clk) disable iff (rst)
        (id_valid && addr[6] == 1'b0 && addr[1:0] == 2'b01) |-> id_data == 8'h20); // R3
    AST_LOCK_RD: assert property (@(posedge clk) disable iff (rst)
        (id_valid && addr[6] == 1'b0 && addr[1:0] == 2'b10) |-> id_data == {7'd0, addr_blocked}); // R4
    AST_NULL: assert property (@(posedge clk) disable iff (rst)
        (id_valid && (addr[6] || addr[1:0] == 2'b11)) |-> id_data == 8'h00); // R5
    AST_RESET_OPEN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sector_block == '0); // R7
    AST_UPD_BIT: assert property (@(posedge clk) disable iff (rst)
        (upd_en && a9_hv) |=> sector_block[$past(upd_sector)] == $past(upd_set)); // R8
    AST_UPD_ONE: assert property (@(posedge clk) disable iff (rst)
        (upd_en && a9_hv) |=> $countones(sector_block ^ $past(sector_block)) <= 1); // R8
    AST_NO_HV_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !a9_hv |=> $stable(sector_block)); // R9
    AST_BLOCK_AGREE: assert property (@(posedge clk) disable iff (rst)
        addr_blocked == sector_block[addr[ADDR_W-1 -: SECT_W]]); // R10
endmodule

bind flash_id_responder flash_id_responder_chk u_chk (.*);

// File: tb/flash_id_responder_tb.sv
module flash_id_responder_tb;
    import flash_id_pkg::*;

    typedef struct {
        logic [7:0] data;
        logic       valid;
        logic [7:0] blk;
        logic       ablk;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, a9_hv = 1'b0;
    logic [16:0] addr = '0;
    logic        upd_en = 1'b0, upd_set = 1'b0;
    logic [2:0]  upd_sector = '0;
    logic [7:0]  id_data;
    logic        id_valid;
    logic [7:0]  sector_block;
    logic        addr_blocked;

    exp_t q[$];
    logic [7:0] model_lock = '0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_id_responder u_dut (.*);

    // Monitor: compares one queued expectation per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (id_data !== e.data || id_valid !== e.valid ||
                    sector_block !== e.blk || addr_blocked !== e.ablk) begin
                    n_fail++;
                    $display("FAIL %s: got data=%h valid=%b blk=%h ablk=%b exp data=%h valid=%b blk=%h ablk=%b",
                             e.tag, id_data, id_valid, sector_block, addr_blocked,
                             e.data, e.valid, e.blk, e.ablk);
                end
            end
        end
    end

    // Driver: applies one read pattern and pushes what the requirements predict.
    task automatic rd(input logic c, input logic o, input logic w, input logic hv,
                      input logic [16:0] a, input string tag);
        exp_t e;
        logic [7:0] d;
        logic on;
        @(posedge clk); #1;
        ce_n = c; oe_n = o; we_n = w; a9_hv = hv; addr = a;
        on = !c && !o && w && hv;
        if (!on) d = 8'h00;
        else if (a[6]) d = 8'h00;
        else case (a[1:0])
            2'b00: d = 8'h01;
            2'b01: d = 8'h20;
            2'b10: d = {7'd0, model_lock[a[16:14]]};
            default: d = 8'h00;
        endcase
        e.data = d; e.valid = on; e.blk = model_lock;
        e.ablk = model_lock[a[16:14]]; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic upd(input logic hv, input logic [2:0] s, input logic v);
        @(posedge clk); #1;
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = hv; upd_en = 1'b1; upd_sector = s; upd_set = v;
        @(posedge clk); #1;
        upd_en = 1'b0;
        if (hv) model_lock[s] = v;
    endtask

    function automatic logic [16:0] mk(input logic [2:0] s, input logic [10:0] dc,
                                       input logic a6, input logic [1:0] lo);
        // dc fills A13..A10, A8..A7, A5..A2 ; A9 left 0 (its level is a9_hv)
        return {s, dc[10:7], 1'b0, dc[6:5], a6, dc[3:0], lo};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R7: reset state, every sector open
        for (int s = 0; s < 8; s++) rd(0, 0, 1, 1, mk(s[2:0], 11'd0, 0, 2'b10), "R7 reset open");
        // R1: gating
        rd(1, 0, 1, 1, mk(0, 0, 0, 2'b00), "R1 ce high");
        rd(0, 1, 1, 1, mk(0, 0, 0, 2'b00), "R1 oe high");
        rd(0, 0, 0, 1, mk(0, 0, 0, 2'b01), "R1 we low");
        rd(0, 0, 1, 0, mk(0, 0, 0, 2'b01), "R1 no hv");
        // R2 R3 R5
        rd(0, 0, 1, 1, mk(5, 0, 0, 2'b00), "R2 maker");
        rd(0, 0, 1, 1, mk(2, 0, 0, 2'b01), "R3 part");
        rd(0, 0, 1, 1, mk(0, 0, 0, 2'b11), "R5 a1a0 both high");
        rd(0, 0, 1, 1, mk(0, 0, 1, 2'b00), "R5 a6 high");
        rd(0, 0, 1, 1, mk(0, 0, 1, 2'b01), "R5 a6 high part slot");
        // R6: don't-care bits varied
        rd(0, 0, 1, 1, mk(3, 11'h7FF, 0, 2'b00), "R6 dc ones maker");
        rd(0, 0, 1, 1, mk(3, 11'h555, 0, 2'b01), "R6 dc mix part");
        // R8 R10: protect sectors 2 and 7
        upd(1, 3'd2, 1'b1);
        rd(0, 0, 1, 1, mk(2, 0, 0, 2'b10), "R8 sector2 locked");
        rd(0, 0, 1, 1, mk(3, 0, 0, 2'b10), "R8 sector3 still open");
        upd(1, 3'd7, 1'b1);
        rd(0, 0, 1, 1, mk(7, 11'h2AA, 0, 2'b10), "R6 R8 sector7 locked dc");
        rd(1, 1, 1, 0, mk(7, 0, 0, 2'b00), "R10 block out for sector7");
        // R9: update without high voltage ignored
        upd(0, 3'd4, 1'b1);
        rd(0, 0, 1, 1, mk(4, 0, 0, 2'b10), "R9 sector4 unchanged");
        upd(0, 3'd2, 1'b0);
        rd(0, 0, 1, 1, mk(2, 0, 0, 2'b10), "R9 sector2 still locked");
        // R8 R10: clearing re-enables
        upd(1, 3'd2, 1'b0);
        rd(0, 0, 1, 1, mk(2, 0, 0, 2'b10), "R8 R10 sector2 reopened");
        rd(1, 1, 1, 0, mk(2, 0, 0, 2'b00), "R10 sector2 not blocked");
        // R7: reset again clears sector 7
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        model_lock = '0;
        rd(0, 0, 1, 1, mk(7, 0, 0, 2'b10), "R7 reset clears sector7");
        @(posedge clk); @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule